// File: doc/BRIEF.md
# Fail-Silence Mute and Staged Re-enable Controller

Each node on a shared multi-drop bus carries one copy of this controller. A healthy bus delivers a periodic keep-alive message. When the keep-alive stops for too long, or when the bus clock line stays low longer than a byte can last, the node turns its transmitter off. Its receiver stays on throughout, so the node can still take recovery commands. A muted non-master node waits for an enable command addressed to it and then starts transmitting again.

The node that acts as bus master runs the recovery. After a fixed wait in the muted state it unmutes itself. It then walks the node indices in ascending order and issues one re-enable request per node. After each request it holds for a settle window and watches for a fresh bus failure. If a failure arrives in that window, the node just enabled goes on a blacklist. Blacklisted nodes are skipped from then on, and only a global reset clears the list. A backup node that is never re-enabled promotes itself to master once its own deadline passes. That deadline is the master's wait plus the backup's rank times a stagger interval, so the lowest rank takes over first.

Top module: `fs_mute_ctrl`

## Requirements
- R1: After reset, tx_en_o=1, rx_en_o=1, reen_valid_o=0 and blacklist_o=0, and master_o equals is_master_i.
- R2: While keepalive_i pulses at intervals shorter than KA_LIMIT cycles, tx_en_o stays 1.
- R3: After KA_LIMIT consecutive cycles without keepalive_i in the running state, tx_en_o goes to 0 (within one cycle of that count).
- R4: rx_en_o is 1 in every state, including while muted.
- R5: When scl_i is held low for BYTE_LIMIT consecutive cycles, tx_en_o goes to 0. Low periods shorter than that have no effect.
- R6: A muted node that is not the active master returns to tx_en_o=1 on the cycle after enable_cmd_i is sampled high.
- R7: An active master that has been muted for UNMUTE_LIMIT cycles sets tx_en_o=1. It then issues single-cycle reen_valid_o pulses with reen_node_o holding node indices in ascending order, skipping its own node_id_i. Consecutive pulses are at least SETTLE_LIMIT cycles apart.
- R8: A bus_fault_i pulse during the settle window after the request for node k sets blacklist_o bit k. Later sequences issue no request for node k.
- R9: Blacklist bits, once set, stay set until rst_n is asserted.
- R10: A muted backup (is_master_i=0) of rank r that gets no enable command raises master_o after UNMUTE_LIMIT + r*STAGGER cycles, turns on tx_en_o and runs the R7 sequence.
- R11: A backup that is re-enabled by enable_cmd_i before its deadline does not promote; master_o stays 0.
- R12: While muted, keepalive_i and scl_i have no effect: tx_en_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global active-low reset, also clears the blacklist |
| keepalive_i | input | 1 | Strobe: a keep-alive message was received |
| scl_i | input | 1 | Level of the bus clock line (0 = held low) |
| enable_cmd_i | input | 1 | Strobe: enable command addressed to this node |
| is_master_i | input | 1 | 1 = controlling master, 0 = backup |
| rank_i | input | RANK_W | Backup takeover priority, 0 first |
| node_id_i | input | IDX_W | Index of this node, skipped in the re-enable walk |
| bus_fault_i | input | 1 | Strobe: the bus failed again |
| tx_en_o | output | 1 | Transmitter (data and clock driver) enable |
| rx_en_o | output | 1 | Receiver enable, always on |
| master_o | output | 1 | Node is the active master (configured or promoted) |
| reen_valid_o | output | 1 | One-cycle re-enable request |
| reen_node_o | output | IDX_W | Node index of the current request |
| blacklist_o | output | NODES | Bit k set: node k is never re-enabled |

## Verification
The bench measures each timeout in exact cycles from a known start. A counter that is off by one or restarts at the wrong time shows up as a mute or unmute outside a one-cycle window. It drives keep-alives and clock-line activity into a muted node, and it sends an enable command to a backup before that backup's deadline. A design that let the watchdogs run while muted would unmute on its own, and one that ignored the command would promote a second master. A fault is injected in the middle of one settle window. The bench then checks that only that node's bit is set, that the next walk skips it alongside the node's own index, and that only reset clears the bit. A backup of rank two is timed to the stagger formula, so a design without rank-scaled delays would take over too early.

// File: rtl/fs_pkg.sv
package fs_pkg;

  typedef enum logic [1:0] {
    M_RUN   = 2'd0,
    M_MUTED = 2'd1,
    M_SEQ   = 2'd2
  } mute_st_t;

  typedef enum logic [1:0] {
    Q_IDLE   = 2'd0,
    Q_PICK   = 2'd1,
    Q_SETTLE = 2'd2
  } seq_st_t;

  // Cycles a muted node waits before taking over recovery.
  function automatic int unsigned unmute_deadline(input logic active_master,
                                                  input int unsigned rank,
                                                  input int unsigned base,
                                                  input int unsigned stagger);
    return active_master ? base : base + rank * stagger;
  endfunction

  // A node index is passed over if it is this node or already blacklisted.
  function automatic logic skip_node(input int unsigned idx,
                                     input int unsigned self_idx,
                                     input logic listed);
    return (idx == self_idx) || listed;
  endfunction

endpackage

// File: rtl/fs_timer.sv
module fs_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt;

  // hit marks the cycle in which the limit-th counted cycle completes
  assign hit = run && !clr && (cnt >= limit - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (run && !hit) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/fs_reseq.sv
module fs_reseq #(
  parameter int NODES        = 4,
  parameter int SETTLE_LIMIT = 8,
  parameter int IDX_W        = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] node_id,
  input  logic             bus_fault,
  output logic             req_valid,
  output logic [IDX_W-1:0] req_node,
  output logic             done,
  output logic [NODES-1:0] blacklist
);
  import fs_pkg::*;

  localparam int SW = $clog2(SETTLE_LIMIT + 1);

  seq_st_t          q_st;
  logic [IDX_W-1:0] idx;
  logic             skip;
  logic             last;
  logic             settle_hit;

  assign skip      = skip_node(32'(idx), 32'(node_id), blacklist[idx]);
  assign last      = (idx == IDX_W'(NODES - 1));
  assign req_valid = (q_st == Q_PICK) && !skip;
  assign req_node  = idx;
  assign done      = ((q_st == Q_PICK) && skip && last) ||
                     ((q_st == Q_SETTLE) && settle_hit && last);

  fs_timer #(.W(SW)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (q_st != Q_SETTLE),
    .run   (1'b1),
    .limit (SW'(SETTLE_LIMIT)),
    .hit   (settle_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_st      <= Q_IDLE;
      idx       <= '0;
      blacklist <= '0;
    end else begin
      case (q_st)
        Q_IDLE: begin
          if (start) begin
            idx  <= '0;
            q_st <= Q_PICK;
          end
        end
        Q_PICK: begin
          if (!skip)     q_st <= Q_SETTLE;
          else if (last) q_st <= Q_IDLE;
          else           idx  <= idx + IDX_W'(1);
        end
        Q_SETTLE: begin
          if (bus_fault) blacklist[idx] <= 1'b1;
          if (settle_hit) begin
            if (last) q_st <= Q_IDLE;
            else begin
              idx  <= idx + IDX_W'(1);
              q_st <= Q_PICK;
            end
          end
        end
        default: q_st <= Q_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fs_mute_ctrl.sv
module fs_mute_ctrl #(
  parameter int NODES        = 4,
  parameter int RANK_W       = 2,
  parameter int KA_LIMIT     = 40,
  parameter int BYTE_LIMIT   = 24,
  parameter int UNMUTE_LIMIT = 60,
  parameter int STAGGER      = 20,
  parameter int SETTLE_LIMIT = 8,
  localparam int IDX_W = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              keepalive_i,
  input  logic              scl_i,
  input  logic              enable_cmd_i,
  input  logic              is_master_i,
  input  logic [RANK_W-1:0] rank_i,
  input  logic [IDX_W-1:0]  node_id_i,
  input  logic              bus_fault_i,
  output logic              tx_en_o,
  output logic              rx_en_o,
  output logic              master_o,
  output logic              reen_valid_o,
  output logic [IDX_W-1:0]  reen_node_o,
  output logic [NODES-1:0]  blacklist_o
);
  import fs_pkg::*;

  localparam int MAX_WAIT = UNMUTE_LIMIT + ((1 << RANK_W) - 1) * STAGGER;
  localparam int MAX_ALL  = MAX_WAIT + KA_LIMIT + BYTE_LIMIT;
  localparam int CNT_W    = $clog2(MAX_ALL + 2);

  mute_st_t st;
  logic     promoted;
  logic     master_act;

  // named internal events, observed by the bound checker
  logic     ka_expire;
  logic     byte_expire;
  logic     unmute_hit;
  logic     seq_start;
  logic     seq_done;
  logic     revive;

  logic [CNT_W-1:0] unmute_lim;

  assign master_act = is_master_i || promoted;
  assign revive     = (st == M_MUTED) && !master_act && enable_cmd_i;
  assign seq_start  = (st == M_MUTED) && unmute_hit && !revive;
  assign unmute_lim = CNT_W'(unmute_deadline(master_act, 32'(rank_i),
                                             UNMUTE_LIMIT, STAGGER));

  // keep-alive watchdog: only armed while running
  fs_timer #(.W(CNT_W)) u_ka (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (keepalive_i || (st != M_RUN)),
    .run   (1'b1),
    .limit (CNT_W'(KA_LIMIT)),
    .hit   (ka_expire)
  );

  // clock-line-low watchdog
  fs_timer #(.W(CNT_W)) u_byte (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (scl_i || (st != M_RUN)),
    .run   (1'b1),
    .limit (CNT_W'(BYTE_LIMIT)),
    .hit   (byte_expire)
  );

  // unmute / takeover deadline, counts only while muted
  fs_timer #(.W(CNT_W)) u_unmute (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st != M_MUTED),
    .run   (1'b1),
    .limit (unmute_lim),
    .hit   (unmute_hit)
  );

  fs_reseq #(
    .NODES        (NODES),
    .SETTLE_LIMIT (SETTLE_LIMIT),
    .IDX_W        (IDX_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (seq_start),
    .node_id   (node_id_i),
    .bus_fault (bus_fault_i),
    .req_valid (reen_valid_o),
    .req_node  (reen_node_o),
    .done      (seq_done),
    .blacklist (blacklist_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= M_RUN;
      promoted <= 1'b0;
    end else begin
      case (st)
        M_RUN: begin
          if (ka_expire || byte_expire) st <= M_MUTED;
        end
        M_MUTED: begin
          if (revive) st <= M_RUN;
          else if (seq_start) begin
            st       <= M_SEQ;
            promoted <= promoted || !is_master_i;
          end
        end
        M_SEQ: begin
          if (seq_done) st <= M_RUN;
        end
        default: st <= M_RUN;
      endcase
    end
  end

  assign tx_en_o  = (st != M_MUTED);
  assign rx_en_o  = 1'b1;
  assign master_o = master_act;
endmodule

// File: rtl/fs_mute_ctrl_chk.sv
module fs_mute_ctrl_chk #(
  parameter int NODES = 4,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable_cmd_i,
  input logic [IDX_W-1:0] node_id_i,
  input logic             tx_en_o,
  input logic             master_o,
  input logic             reen_valid_o,
  input logic [IDX_W-1:0] reen_node_o,
  input logic [NODES-1:0] blacklist_o,
  input logic             ka_expire,
  input logic             byte_expire,
  input logic             unmute_hit
);
  p_mute_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en_o) |-> $past(ka_expire || byte_expire));

  p_unmute_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en_o) |-> $past(enable_cmd_i || unmute_hit));

  p_req_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reen_valid_o |=> !reen_valid_o);

  p_req_while_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reen_valid_o |-> tx_en_o);

  p_skip_listed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reen_valid_o |-> (!blacklist_o[reen_node_o] && (reen_node_o != node_id_i)));

  p_list_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(blacklist_o) & ~blacklist_o) == '0));

  p_master_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    master_o |=> master_o);
endmodule

bind fs_mute_ctrl fs_mute_ctrl_chk #(.NODES(NODES), .IDX_W(IDX_W)) i_chk (.*);

// File: tb/test_fs_mute_ctrl.sv
module test_fs_mute_ctrl;
  localparam int NODES = 4;
  localparam int KA    = 40;
  localparam int BYTE  = 24;
  localparam int UNM   = 60;
  localparam int STG   = 20;
  localparam int SET   = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       keepalive_i = 1'b0;
  logic       scl_i = 1'b1;
  logic       enable_cmd_i = 1'b0;
  logic       is_master_i = 1'b0;
  logic [1:0] rank_i = 2'd0;
  logic [1:0] node_id_i = 2'd0;
  logic       bus_fault_i = 1'b0;
  logic       tx_en_o, rx_en_o, master_o, reen_valid_o;
  logic [1:0] reen_node_o;
  logic [3:0] blacklist_o;

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  logic ka_auto = 1'b0;
  logic ka_force = 1'b0;
  logic finished = 1'b0;

  int got_node [16];
  int got_cyc  [16];
  int got_cnt = 0;

  fs_mute_ctrl #(
    .NODES(NODES), .RANK_W(2), .KA_LIMIT(KA), .BYTE_LIMIT(BYTE),
    .UNMUTE_LIMIT(UNM), .STAGGER(STG), .SETTLE_LIMIT(SET)
  ) i_fs_mute_ctrl (.*);

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    keepalive_i <= ka_auto ? ((cyc % 10) == 0) : ka_force;
    if (reen_valid_o && got_cnt < 16) begin
      got_node[got_cnt] = int'(reen_node_o);
      got_cyc[got_cnt]  = cyc;
      got_cnt++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // which: 0 = tx_en_o, 1 = master_o
  task automatic wait_sig(input int which, input logic val, output int n);
    n = 0;
    while (((which == 0) ? tx_en_o : master_o) !== val && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_reset(input logic mst, input logic [1:0] rnk,
                          input logic [1:0] id, input logic auto_ka);
    @(negedge clk);
    rst_n = 1'b0;
    is_master_i = mst;
    rank_i = rnk;
    node_id_i = id;
    ka_auto = auto_ka;
    ka_force = 1'b0;
    scl_i = 1'b1;
    enable_cmd_i = 1'b0;
    bus_fault_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    got_cnt = 0;
  endtask

  task automatic t_reset_state();
    do_reset(1'b0, 2'd1, 2'd3, 1'b1);
    chk("R1 tx after reset", int'(tx_en_o), 1);
    chk("R4 rx after reset", int'(rx_en_o), 1);
    chk("R1 master follows role (backup)", int'(master_o), 0);
    chk("R1 blacklist clear", int'(blacklist_o), 0);
    chk("R1 no request", int'(reen_valid_o), 0);
    do_reset(1'b1, 2'd0, 2'd1, 1'b1);
    chk("R1 master follows role (master)", int'(master_o), 1);
  endtask

  task automatic t_keepalive();
    int drops = 0;
    do_reset(1'b0, 2'd1, 2'd3, 1'b1);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (tx_en_o !== 1'b1) drops++;
    end
    chk("R2 tx held by keep-alive", drops, 0);
  endtask

  task automatic t_silence_backup();
    int n;
    int off_seen = 0;
    int rx_off = 0;
    do_reset(1'b0, 2'd1, 2'd3, 1'b0);
    wait_sig(0, 1'b0, n);
    chk_rng("R3 keep-alive timeout", n, KA - 1, KA + 1);
    // stimulus while muted must not reopen the transmitter
    ka_auto = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      scl_i = (i % 3 == 0);
      if (tx_en_o !== 1'b0) off_seen++;
      if (rx_en_o !== 1'b1) rx_off++;
    end
    scl_i = 1'b1;
    chk("R12 ignored while muted", off_seen, 0);
    chk("R4 rx on while muted", rx_off, 0);
    enable_cmd_i = 1'b1;
    @(negedge clk);
    enable_cmd_i = 1'b0;
    chk("R6 enable command unmutes", int'(tx_en_o), 1);
    repeat (120) @(negedge clk);
    chk("R11 no promotion after enable", int'(master_o), 0);
    chk("R11 no requests from backup", got_cnt, 0);
  endtask

  task automatic t_byte();
    int n;
    do_reset(1'b0, 2'd1, 2'd3, 1'b1);
    for (int r = 0; r < 3; r++) begin
      scl_i = 1'b0;
      repeat (BYTE - 6) @(negedge clk);
      scl_i = 1'b1;
      repeat (4) @(negedge clk);
    end
    chk("R5 short low periods ignored", int'(tx_en_o), 1);
    scl_i = 1'b0;
    wait_sig(0, 1'b0, n);
    chk_rng("R5 clock-low timeout", n, BYTE - 1, BYTE + 1);
    scl_i = 1'b1;
  endtask

  task automatic t_master();
    int n;
    do_reset(1'b1, 2'd0, 2'd1, 1'b0);
    wait_sig(0, 1'b0, n);
    chk_rng("R3 master keep-alive timeout", n, KA - 1, KA + 1);
    wait_sig(0, 1'b1, n);
    chk_rng("R7 master unmute wait", n, UNM - 1, UNM + 1);
    n = 0;
    while (got_cnt < 2 && n < 200) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    bus_fault_i = 1'b1;
    @(negedge clk);
    bus_fault_i = 1'b0;
    repeat (3 * SET) @(negedge clk);
    chk("R7 request count", got_cnt, 3);
    chk("R7 first node", got_node[0], 0);
    chk("R7 own index skipped", got_node[1], 2);
    chk("R7 last node", got_node[2], 3);
    chk_rng("R7 settle spacing", got_cyc[1] - got_cyc[0], SET, SET + 4);
    chk("R8 faulted node listed", int'(blacklist_o), 4);
    // second round: listed node must be passed over
    got_cnt = 0;
    wait_sig(0, 1'b0, n);
    wait_sig(0, 1'b1, n);
    repeat (4 * SET) @(negedge clk);
    chk("R8 second round count", got_cnt, 2);
    chk("R8 second round first", got_node[0], 0);
    chk("R8 listed node skipped", got_node[1], 3);
    chk("R9 list kept", int'(blacklist_o), 4);
    do_reset(1'b1, 2'd0, 2'd1, 1'b1);
    chk("R9 reset clears list", int'(blacklist_o), 0);
  endtask

  task automatic t_backup_takeover();
    int n;
    do_reset(1'b0, 2'd2, 2'd3, 1'b0);
    wait_sig(0, 1'b0, n);
    wait_sig(1, 1'b1, n);
    chk_rng("R10 rank-2 takeover delay", n, UNM + 2 * STG - 1, UNM + 2 * STG + 1);
    chk("R10 tx on after takeover", int'(tx_en_o), 1);
    repeat (4 * SET) @(negedge clk);
    chk("R10 request count", got_cnt, 3);
    chk("R10 nodes in order", got_node[0] * 100 + got_node[1] * 10 + got_node[2], 12);
  endtask

  initial begin
    t_reset_state();
    t_keepalive();
    t_silence_backup();
    t_byte();
    t_master();
    t_backup_takeover();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule